// File: doc/BRIEF.md
# Replicated Shared Memory with Arbitrated Write Channels

This block is a small shared data memory for a cluster of processors. Each processor has its own read port. A read never waits: every processor can read any word in every cycle. Writes travel over a fixed, smaller set of write channels. The number of channels is a parameter, independent of the processor count.

To give each reader a private port, the storage is held in one full copy per processor. Each copy has a single read port and one write port per channel. Every write channel is broadcast to all copies at once, so the copies stay identical.

An allocator looks at the processors raising a write request in a cycle. It assigns free channels in ascending channel order, picking requesters in a rotating order. A write completes on the clock edge that ends its grant cycle, and the channel is then free again. A requester that receives no channel in a cycle is stalled. It holds its request, address and data until a grant arrives.

Top module: `rmw_mem`

## Requirements
- R1: After reset every word of every copy reads as zero, every read output is zero, and no grant is raised while no write is requested.
- R2: Each read port returns, on its output in the cycle after the address is presented, the word stored at that address. All read ports are served in the same cycle.
- R3: A granted write is seen by every read port: a read issued in any later cycle returns the new word.
- R4: A read of an address that is written in the same cycle returns the value held before that write.
- R5: No more than NWCH grants are raised in a cycle. When NWCH or more writes are requested, exactly NWCH are granted, and each grant fills one channel.
- R6: A grant goes only to a requester in the cycle of its request. A requester without a grant is stalled and leaves the storage unchanged. It must keep its request, address and data stable until granted.
- R7: Requesters are scanned in rotating order. The scan starts at a pointer that is 0 after reset, and a requester is granted if a channel is still free when it is reached. After any grant, the pointer moves to the index one past the last requester granted, modulo NPROC.
- R8: Channels are filled in ascending index order, following the scan order of R7. When two granted writes target the same address in one cycle, the write on the lower channel, which was scanned first, is the one kept in every copy.
- R9: A requester that holds its request is granted within NPROC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr | input | NPROC*AW | Read address per processor, processor i in bits [i*AW +: AW] |
| rd_data | output | NPROC*DW | Read data per processor, one cycle after its address |
| wr_req | input | NPROC | Write request per processor |
| wr_addr | input | NPROC*AW | Write address per processor |
| wr_data | input | NPROC*DW | Write data per processor |
| wr_gnt | output | NPROC | Grant per processor, combinational in the request cycle; request without grant means stall |

## Verification
A grant is due in the same cycle as its request. The bench drives inputs just after the falling edge, waits one time unit, and compares wr_gnt before the rising edge. Read data is due one rising edge after the address. The bench works out the expected word from its model before it applies that cycle's writes, and compares rd_data at the next falling edge. A granted write becomes visible to reads issued in the following cycle, so the model commits writes only after it has recorded the expected reads of the same cycle.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
    // next index in a ring of n entries
    function automatic int ring_next(input int i, input int n);
        return (i + 1) % n;
    endfunction
endpackage

// File: rtl/rmw_arbiter.sv
module rmw_arbiter #(
    parameter int NPROC = 4,
    parameter int NWCH  = 2,
    localparam int PW   = $clog2(NPROC),
    localparam int CW   = (NWCH > 1) ? $clog2(NWCH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPROC-1:0]           req,
    output logic [NPROC-1:0]           gnt,
    output logic [NWCH-1:0]            ch_vld,
    output logic [NWCH-1:0][PW-1:0]    ch_src
);
    import rmw_pkg::*;

    typedef struct packed {
        logic [PW-1:0] ptr;
    } arb_t;

    arb_t st_d, st_q;

    always_comb begin
        int cnt;
        int idx;
        int last;
        logic hit;
        st_d   = st_q;
        gnt    = '0;
        ch_vld = '0;
        ch_src = '0;
        cnt    = 0;
        idx    = 0;
        last   = int'(st_q.ptr);
        hit    = 1'b0;
        for (int k = 0; k < NPROC; k++) begin
            idx = (int'(st_q.ptr) + k) % NPROC;
            if (req[PW'(idx)] && cnt < NWCH) begin
                gnt[PW'(idx)]    = 1'b1;
                ch_vld[CW'(cnt)] = 1'b1;
                ch_src[CW'(cnt)] = PW'(idx);
                cnt  = cnt + 1;
                last = idx;
                hit  = 1'b1;
            end
        end
        if (hit) st_d.ptr = PW'(ring_next(last, NPROC));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_GRANT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt) <= NWCH); // R5
    AST_GRANT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(req) >= NWCH) |-> ($countones(gnt) == NWCH)); // R5
    AST_CH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ch_vld) == $countones(gnt)); // R5
    AST_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R6

    for (genvar c = 1; c < NWCH; c++) begin : g_order
        AST_CH_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
            ch_vld[c] |-> ch_vld[c-1]); // R8
    end
endmodule

// File: rtl/rmw_bank.sv
module rmw_bank #(
    parameter int NWCH = 2,
    parameter int AW   = 4,
    parameter int DW   = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NWCH-1:0]            wen,
    input  logic [NWCH-1:0][AW-1:0]    waddr,
    input  logic [NWCH-1:0][DW-1:0]    wdata,
    input  logic [AW-1:0]              raddr,
    output logic [DW-1:0]              rdata
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [DW-1:0]            rd;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        // read sees the contents before this cycle's writes
        st_d.rd = st_q.mem[raddr];
        // highest channel first so the lowest channel is applied last and wins
        for (int c = NWCH - 1; c >= 0; c--) begin
            if (wen[c]) st_d.mem[waddr[c]] = wdata[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rd;
endmodule

// File: rtl/rmw_mem.sv
module rmw_mem #(
    parameter int NPROC = 4,
    parameter int NWCH  = 2,
    parameter int AW    = 4,
    parameter int DW    = 8,
    localparam int PW   = $clog2(NPROC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPROC*AW-1:0]     rd_addr,
    output logic [NPROC*DW-1:0]     rd_data,
    input  logic [NPROC-1:0]        wr_req,
    input  logic [NPROC*AW-1:0]     wr_addr,
    input  logic [NPROC*DW-1:0]     wr_data,
    output logic [NPROC-1:0]        wr_gnt
);
    logic [NPROC-1:0][AW-1:0]   ra_v, wa_v;
    logic [NPROC-1:0][DW-1:0]   wd_v, rd_v;
    logic [NWCH-1:0]            ch_vld;
    logic [NWCH-1:0][PW-1:0]    ch_src;
    logic [NWCH-1:0][AW-1:0]    ch_addr;
    logic [NWCH-1:0][DW-1:0]    ch_data;

    assign ra_v    = rd_addr;
    assign wa_v    = wr_addr;
    assign wd_v    = wr_data;
    assign rd_data = rd_v;

    rmw_arbiter #(.NPROC(NPROC), .NWCH(NWCH)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (wr_req),
        .gnt    (wr_gnt),
        .ch_vld (ch_vld),
        .ch_src (ch_src)
    );

    // route each granted requester onto its broadcast channel
    always_comb begin
        for (int c = 0; c < NWCH; c++) begin
            ch_addr[c] = wa_v[ch_src[c]];
            ch_data[c] = wd_v[ch_src[c]];
        end
    end

    for (genvar i = 0; i < NPROC; i++) begin : g_copy
        rmw_bank #(.NWCH(NWCH), .AW(AW), .DW(DW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wen   (ch_vld),
            .waddr (ch_addr),
            .wdata (ch_data),
            .raddr (ra_v[i]),
            .rdata (rd_v[i])
        );

        AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_req[i] && !wr_gnt[i]) |=> (wr_req[i] && $stable(wa_v[i]) && $stable(wd_v[i]))); // R6

        if (i > 0) begin : g_coh
            AST_COPY_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
                (ra_v[i] == ra_v[0]) |=> (rd_v[i] == rd_v[0])); // R3
        end
    end
endmodule

// File: tb/sim_rmw_mem.sv
`timescale 1ns/1ps
module sim_rmw_mem;
    localparam int N  = 4;
    localparam int C  = 2;
    localparam int AW = 4;
    localparam int DW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N*AW-1:0] rd_addr = '0;
    logic [N*DW-1:0] rd_data;
    logic [N-1:0]    wr_req = '0;
    logic [N*AW-1:0] wr_addr = '0;
    logic [N*DW-1:0] wr_data = '0;
    logic [N-1:0]    wr_gnt;

    always #2.5 clk = ~clk;

    rmw_mem #(.NPROC(N), .NWCH(C), .AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_gnt(wr_gnt)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] mm [16];
    bit            lastw [16];
    int            ptr_m = 0;
    bit            pend [N];
    logic [AW-1:0] pa [N];
    logic [DW-1:0] pd [N];
    logic [AW-1:0] ra [N];
    int            waitc [N];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one cycle: called just after a falling edge, returns just after the next one
    task automatic step(input string force_tag);
        logic [N-1:0]  eg;
        int            ord [C];
        int            cnt;
        int            last;
        logic [DW-1:0] exp_rd [N];
        string         tg [N];
        bit            wnow [16];
        for (int i = 0; i < N; i++) begin
            wr_req[i]             = pend[i];
            wr_addr[i*AW +: AW]   = pa[i];
            wr_data[i*DW +: DW]   = pd[i];
            rd_addr[i*AW +: AW]   = ra[i];
        end
        #1;
        eg = '0; cnt = 0; last = ptr_m;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (ptr_m + k) % N;
            if (pend[idx] && cnt < C) begin
                eg[idx] = 1'b1; ord[cnt] = idx; cnt++; last = idx;
            end
        end
        chk(wr_gnt == eg, "R7 grant vector", int'(wr_gnt), int'(eg));
        chk($countones(wr_gnt) <= C, "R5 grant count", $countones(wr_gnt), C);
        chk((wr_gnt & ~wr_req) == '0, "R6 grant without request", int'(wr_gnt), int'(wr_req));
        for (int a = 0; a < 16; a++) wnow[a] = 0;
        for (int j = 0; j < cnt; j++) wnow[pa[ord[j]]] = 1;
        for (int i = 0; i < N; i++) begin
            exp_rd[i] = mm[ra[i]];
            if (force_tag != "")   tg[i] = force_tag;
            else if (wnow[ra[i]])  tg[i] = "R4 same-cycle read";
            else if (lastw[ra[i]]) tg[i] = "R3 read after write";
            else                   tg[i] = "R2 read";
        end
        for (int j = cnt - 1; j >= 0; j--) mm[pa[ord[j]]] = pd[ord[j]];
        if (cnt > 0) ptr_m = (last + 1) % N;
        for (int a = 0; a < 16; a++) lastw[a] = wnow[a];
        for (int i = 0; i < N; i++) begin
            if (eg[i]) begin
                pend[i] = 0; waitc[i] = 0;
            end else if (pend[i]) begin
                waitc[i]++;
                chk(waitc[i] < N, "R9 wait bound", waitc[i], N - 1);
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < N; i++)
            chk(rd_data[i*DW +: DW] == exp_rd[i], tg[i], int'(rd_data[i*DW +: DW]), int'(exp_rd[i]));
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int a = 0; a < 16; a++) begin mm[a] = '0; lastw[a] = 0; end
        for (int i = 0; i < N; i++) begin pend[i] = 0; pa[i] = '0; pd[i] = '0; ra[i] = '0; waitc[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(rd_data == '0, "R1 read outputs after reset", int'(rd_data[31:0]), 0);
        chk(wr_gnt == '0, "R1 no grant when idle", int'(wr_gnt), 0);
        for (int i = 0; i < N; i++) ra[i] = AW'(i * 5);
        step("R1 memory cleared");
        for (int i = 0; i < N; i++) ra[i] = AW'(15 - i);
        step("R1 memory cleared");

        // R8: all requesters collide on one address, twice
        for (int i = 0; i < N; i++) begin
            pend[i] = 1; pa[i] = 4'd5; pd[i] = DW'(8'hA0 + i); ra[i] = 4'd5;
        end
        step("R4 collision read old");
        step("R8 collision winner");
        step("R8 collision winner");

        // R4 then R3: single write, read same cycle and next cycle
        pend[2] = 1; pa[2] = 4'd9; pd[2] = 8'h3C;
        for (int i = 0; i < N; i++) ra[i] = 4'd9;
        step("");
        step("");

        // R5/R6: everyone requests distinct addresses, only two per cycle
        for (int i = 0; i < N; i++) begin
            pend[i] = 1; pa[i] = AW'(i + 10); pd[i] = DW'(8'h50 + i); ra[i] = AW'(i + 10);
        end
        step(""); step(""); step("");

        // constrained random traffic
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < N; i++) begin
                if (!pend[i] && $urandom_range(0, 99) < 60) begin
                    pend[i] = 1;
                    pa[i] = ($urandom_range(0, 1) == 0) ? AW'($urandom_range(0, 3)) : AW'($urandom_range(0, 15));
                    pd[i] = DW'($urandom);
                end
                ra[i] = AW'($urandom_range(0, 15));
            end
            step("");
        end
        for (int n = 0; n < N; n++) step("");
        for (int a = 0; a < 16; a++) begin
            for (int i = 0; i < N; i++) ra[i] = AW'(a);
            step("R3 final contents");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule